// File: doc/BRIEF.md
# Packed SIMD Lane ALU with Per-Lane Status

This block is a 64-bit packed-integer execution unit. One operation is issued per cycle. Each operation treats both operands as a row of independent lanes of 8, 16 or 32 bits, chosen by the lane-size input. The operations are lane compares, signed and unsigned minimum and maximum, wrapping add and subtract, rounding average, and low-half or high-half interleave. A compare fills a lane with all ones when its condition holds, so the result can be used directly as a select mask.

Next to the 64-bit result, the block returns a 32-bit status word. It packs a negative flag and a zero flag for every lane. Where those flags sit depends on the lane size, and every other bit of the word stays zero. Result, status and an output strobe are registered and appear one cycle after the input strobe.

Top module: `simd_lane_alu`

## Requirements
- R1: When `valid_i` is high at a rising clock edge, `valid_o` is high after that edge and `result_o`/`flags_o` hold that operation's outcome. When `valid_i` is low, `valid_o` goes low and `result_o`/`flags_o` keep their previous values whatever the other inputs do.
- R2: While `rst_ni` is low, `valid_o`, `result_o` and `flags_o` are zero.
- R3: Compares set a lane to all ones when the condition holds, otherwise to zero: opcode 0 tests equal, opcode 1 tests signed A > B, opcode 2 tests unsigned A > B.
- R4: Min and max return the winning lane of A or B unchanged: opcode 3 signed min, 4 unsigned min, 5 signed max, 6 unsigned max.
- R5: Opcode 7 (A + B) and opcode 8 (A − B) wrap modulo the lane width, and no carry or borrow crosses into the next lane.
- R6: Opcode 9 gives floor((a + b) / 2) per lane and opcode 10 gives floor((a + b + 1) / 2), computed without losing the carry. For these opcodes every negative flag is zero.
- R7: Opcode 11 (low) and opcode 12 (high) interleave. Destination lane 2k takes source lane k of A (even) and lane 2k+1 takes source lane k of B (odd). The source lanes come from bits 31:0 for low and from bits 63:32 for high.
- R8: Lane size `size_i` is 0 for 8-bit, 1 for 16-bit, 2 or 3 for 32-bit lanes. With S = lane width / 2, lane i has its negative flag (lane MSB) at status bit S·i+S−1 and its zero flag at bit S·i+S−2. So 8-bit lanes use bits 4i+3 and 4i+2, 16-bit lanes 8i+7 and 8i+6, and 32-bit lanes 16i+15 and 16i+14.
- R9: Status bits that are not a flag position of the active lane size are zero.
- R10: Opcodes 13 to 15 are undefined and give a zero result and a zero status word, still with `valid_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Issue strobe for the operation on the inputs |
| op_i | input | 4 | Opcode (R3–R7, R10) |
| size_i | input | 2 | Lane size select (R8) |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 64 | Registered lane result |
| flags_o | output | 32 | Registered per-lane negative/zero status |

## Verification
Two things meet in one cycle. The first is the lane result. The second is the status word, whose layout moves with the lane size. A wrong lane value, or a flag written at the position of another lane size, appears in the same registered output. The bench mixes random opcodes, lane sizes and operands with directed cases: sign-boundary bytes, lanes that are all ones, carries at lane edges, and zero lanes that set a flag in the middle of the word. It compares result and status together against a behavioural model, one cycle after issue. Idle cycles with changing operands then show that both outputs hold.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [3:0] {
    OP_CMPEQ  = 4'd0,
    OP_CMPGTS = 4'd1,
    OP_CMPGTU = 4'd2,
    OP_MINS   = 4'd3,
    OP_MINU   = 4'd4,
    OP_MAXS   = 4'd5,
    OP_MAXU   = 4'd6,
    OP_ADD    = 4'd7,
    OP_SUB    = 4'd8,
    OP_AVG    = 4'd9,
    OP_AVGR   = 4'd10,
    OP_UNPKLO = 4'd11,
    OP_UNPKHI = 4'd12
  } op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_W2 = 2'd3
  } size_e;

  localparam logic [3:0] OP_LAST = 4'd12;
endpackage

// File: rtl/simd_lane_slice.sv
module simd_lane_slice
  import simd_alu_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic [3:0]        op_i,
  output logic [LANE_W-1:0] y_o
);
  localparam logic [LANE_W-1:0] ONES = {LANE_W{1'b1}};

  logic gts, gtu, lts, ltu, rnd, carry_half;
  logic [LANE_W-1:0] avg;

  assign gts = $signed(a_i) > $signed(b_i);
  assign gtu = a_i > b_i;
  assign lts = $signed(a_i) < $signed(b_i);
  assign ltu = a_i < b_i;
  assign rnd = (op_i == OP_AVGR);
  // floor((a+b+r)/2) without widening: halves plus majority of the LSBs
  assign carry_half = (a_i[0] & b_i[0]) | ((a_i[0] | b_i[0]) & rnd);
  assign avg = (a_i >> 1) + (b_i >> 1) + {{(LANE_W-1){1'b0}}, carry_half};

  always_comb begin
    unique case (op_i)
      OP_CMPEQ:       y_o = (a_i == b_i) ? ONES : '0;
      OP_CMPGTS:      y_o = gts ? ONES : '0;
      OP_CMPGTU:      y_o = gtu ? ONES : '0;
      OP_MINS:        y_o = lts ? a_i : b_i;
      OP_MINU:        y_o = ltu ? a_i : b_i;
      OP_MAXS:        y_o = gts ? a_i : b_i;
      OP_MAXU:        y_o = gtu ? a_i : b_i;
      OP_ADD:         y_o = a_i + b_i;
      OP_SUB:         y_o = a_i - b_i;
      OP_AVG, OP_AVGR: y_o = avg;
      default:        y_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_size_path.sv
module simd_size_path
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [3:0]          op_i,
  output logic [DATA_W-1:0]   res_o,
  output logic [DATA_W/2-1:0] flags_o
);
  localparam int NLANE  = DATA_W / LANE_W;
  localparam int HALF   = NLANE / 2;
  localparam int STRIDE = LANE_W / 2;

  logic known, is_unpk, is_hi, is_avg;
  assign known   = (op_i <= OP_LAST);
  assign is_unpk = (op_i == OP_UNPKLO) || (op_i == OP_UNPKHI);
  assign is_hi   = (op_i == OP_UNPKHI);
  assign is_avg  = (op_i == OP_AVG) || (op_i == OP_AVGR);

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int SRC_LO = i / 2;
    localparam int SRC_HI = i / 2 + HALF;
    logic [LANE_W-1:0] arith, pick_lo, pick_hi, lane_y;
    logic neg, zero;

    simd_lane_slice #(.LANE_W(LANE_W)) slice_i (
      .a_i (a_i[i*LANE_W +: LANE_W]),
      .b_i (b_i[i*LANE_W +: LANE_W]),
      .op_i(op_i),
      .y_o (arith)
    );

    if (i % 2 == 0) begin : g_even
      assign pick_lo = a_i[SRC_LO*LANE_W +: LANE_W];
      assign pick_hi = a_i[SRC_HI*LANE_W +: LANE_W];
    end else begin : g_odd
      assign pick_lo = b_i[SRC_LO*LANE_W +: LANE_W];
      assign pick_hi = b_i[SRC_HI*LANE_W +: LANE_W];
    end

    assign lane_y = !is_unpk ? arith : (is_hi ? pick_hi : pick_lo);
    assign neg    = known & ~is_avg & lane_y[LANE_W-1];
    assign zero   = known & (lane_y == '0);

    assign res_o[i*LANE_W +: LANE_W]   = lane_y;
    assign flags_o[i*STRIDE +: STRIDE] = {neg, zero, {(STRIDE-2){1'b0}}};
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W/2-1:0] flags_o
);
  localparam int NSIZE = 3;
  localparam int STAT_W = DATA_W / 2;

  logic [DATA_W-1:0] res_sz [NSIZE];
  logic [STAT_W-1:0] flg_sz [NSIZE];

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    simd_size_path #(.DATA_W(DATA_W), .LANE_W(8 << s)) path_i (
      .a_i    (a_i),
      .b_i    (b_i),
      .op_i   (op_i),
      .res_o  (res_sz[s]),
      .flags_o(flg_sz[s])
    );
  end

  logic [DATA_W-1:0] res_d;
  logic [STAT_W-1:0] flg_d;

  always_comb begin
    unique case (size_e'(size_i))
      SZ_B:    begin res_d = res_sz[0]; flg_d = flg_sz[0]; end
      SZ_H:    begin res_d = res_sz[1]; flg_d = flg_sz[1]; end
      default: begin res_d = res_sz[2]; flg_d = flg_sz[2]; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        flags_o  <= flg_d;
      end
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic [DATA_W/2-1:0] flags_o
);
  a_r1_strobe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r1_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(flags_o)));

  a_r9_byte_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd0) |=> ((flags_o & 32'h3333_3333) == 32'h0));

  a_r9_half_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd1) |=> ((flags_o & 32'h3F3F_3F3F) == 32'h0));

  a_r9_word_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i[1]) |=> ((flags_o & 32'h3FFF_3FFF) == 32'h0));

  a_r6_avg_no_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd9 || op_i == 4'd10)) |=> ((flags_o & 32'h8888_8888) == 32'h0));

  a_r8_byte0_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd0 && op_i <= 4'd12) |=> (flags_o[2] == (result_o[7:0] == 8'h00)));

  a_r3_eq_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd0 && size_i == 2'd0) |=> (result_o[7:0] == 8'h00 || result_o[7:0] == 8'hFF));

  a_r10_undef_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 4'd12) |=> (result_o == '0 && flags_o == '0));
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/simd_lane_alu_tb_top.sv
module simd_lane_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [31:0] flags_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  simd_lane_alu dut_i (.*);

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 2) return "R3";
    if (op <= 6) return "R4";
    if (op <= 8) return "R5";
    if (op <= 10) return "R6";
    if (op <= 12) return "R7";
    return "R10";
  endfunction

  function automatic logic [63:0] lane_get(input logic [63:0] v, input int idx, input int w);
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 1);
    return (v >> (idx * w)) & m;
  endfunction

  function automatic longint to_signed(input logic [63:0] u, input int w);
    longint s = longint'(u);
    if (u[w-1]) s = s - (longint'(1) << w);
    return s;
  endfunction

  function automatic void ref_model(input logic [3:0] op, input logic [1:0] sz,
                                    input logic [63:0] a, input logic [63:0] b,
                                    output logic [63:0] r, output logic [31:0] f);
    int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    int n = 64 / w;
    int st = w / 2;
    logic [63:0] m = (64'd1 << w) - 1;
    r = '0; f = '0;
    if (op > 12) return;
    for (int i = 0; i < n; i++) begin
      logic [63:0] ua = lane_get(a, i, w), ub = lane_get(b, i, w), v;
      longint sa = to_signed(ua, w), sb = to_signed(ub, w);
      case (op)
        0: v = (ua == ub) ? m : 0;
        1: v = (sa > sb) ? m : 0;
        2: v = (ua > ub) ? m : 0;
        3: v = (sa < sb) ? ua : ub;
        4: v = (ua < ub) ? ua : ub;
        5: v = (sa > sb) ? ua : ub;
        6: v = (ua > ub) ? ua : ub;
        7: v = ua + ub;
        8: v = ua - ub;
        9: v = (ua + ub) >> 1;
        10: v = (ua + ub + 1) >> 1;
        default: begin
          int src = i / 2 + ((op == 12) ? n / 2 : 0);
          v = (i % 2 == 0) ? lane_get(a, src, w) : lane_get(b, src, w);
        end
      endcase
      v = v & m;
      r |= v << (i * w);
      if (v == 0) f[i*st + st - 2] = 1'b1;
      if (op != 9 && op != 10 && v[w-1]) f[i*st + st - 1] = 1'b1;
    end
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er; logic [31:0] ef;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; size_i = sz; a_i = a; b_i = b;
    ref_model(op, sz, a, b, er, ef);
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R1", "valid_o", 64'(valid_o), 64'd1);
    check(tag_of(op), "result", result_o, er);
    check((op == 9 || op == 10) ? "R6" : "R8", "status", 64'(flags_o), 64'(ef));
  endtask

  initial begin
    logic [63:0] hold_r; logic [31:0] hold_f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R2", "reset valid_o", 64'(valid_o), 0);
    check("R2", "reset result", result_o, 0);
    check("R2", "reset status", 64'(flags_o), 0);
    rst_ni = 1'b1;

    // directed corners
    run_op(4'd1, 2'd0, 64'h80, 64'h7F);                        // R3 signed: -128 > 127 false
    run_op(4'd2, 2'd0, 64'h80, 64'h7F);                        // R3 unsigned true
    run_op(4'd0, 2'd1, 64'h1234_0000_FFFF_0001, 64'h1234_0001_FFFF_0001);
    run_op(4'd3, 2'd2, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF); // R4
    run_op(4'd6, 2'd0, 64'hFF01_7F80_0000_00FF, 64'h01FF_807F_0000_FF00);
    run_op(4'd7, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001); // R5 no carry across
    run_op(4'd8, 2'd1, 64'h0000_0000_0000_0000, 64'h0001_0000_0001_0000); // R5 borrow wrap
    run_op(4'd10, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF); // R6 carry kept
    run_op(4'd9, 2'd1, 64'h0001_8000_FFFF_0000, 64'h0000_8000_FFFF_0000);
    run_op(4'd11, 2'd0, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988); // R7
    run_op(4'd12, 2'd1, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988);
    run_op(4'd12, 2'd3, 64'h8000_0000_0000_0000, 64'h0000_0000_1111_1111); // R8 size 3 as word
    run_op(4'd14, 2'd0, 64'h1234, 64'h1234);                  // R10

    // R1 hold: idle cycle with changing operands
    hold_r = result_o; hold_f = flags_o;
    @(negedge clk_i);
    op_i = 4'd7; a_i = 64'h5555; b_i = 64'h1;
    @(negedge clk_i);
    check("R1", "idle valid_o", 64'(valid_o), 0);
    check("R1", "idle result hold", result_o, hold_r);
    check("R1", "idle status hold", 64'(flags_o), 64'(hold_f));

    // random mix, with zero-lane bias
    for (int k = 0; k < 600; k++) begin
      logic [63:0] ra = {$urandom, $urandom}, rb = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) rb = ra;
      if ($urandom_range(0, 3) == 0) ra = ra & 64'hFFFF_0000_FF00_00FF;
      run_op(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), ra, rb);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule